// File: doc/BRIEF.md
# Physical Page Ownership Checker

This block holds one ownership record for every 4 KB physical page, indexed by the physical page number. Each memory access to a private guest page is checked against that record. The record states whether the page is assigned, which context (address-space identifier) owns it, the guest-physical page it should be mapped at, whether the guest has accepted it, and read/write/execute rights for each of four privilege levels. If a host remaps a page behind the guest's back, the new page has not been accepted, or it is recorded under a different guest address. Either way the access faults.

A privileged host operation arrives on the update port. It assigns a page to a context at a guest-physical address, or releases it. The page then waits in the assigned-but-unaccepted state. The guest accepts the page through the accept port. The check port is pipelined: it takes one request per cycle and returns pass or a fault code two cycles later. One cycle reads the table and the next compares.

Top module: `page_owner_check`

## Requirements
- R1: After a synchronous reset every page is unassigned, and `res_valid`, `res_fault` and `res_code` are all 0. While `res_valid` is 0, `res_fault` and `res_code` stay 0.
- R2: A check request presented in cycle t gives its result, with `res_valid`=1, after the second rising edge. Requests may arrive on every cycle.
- R3: A check with `chk_private`=0 always passes with code 0, whatever the table holds.
- R4: A private check to an unassigned page faults with code 1.
- R5: A private check whose context differs from the owner faults with code 2. A private check whose guest page number (`chk_gpa[GA_W-1:12]`) differs from the recorded one faults with code 3.
- R6: A private check to an owned, matching page that has not been accepted faults with code 4.
- R7: A host update (`upd_assign`=1 assigns, 0 releases) writes the owner, guest page, permissions and lock flag. It always clears the accepted flag. `upd_done` pulses one cycle after the request, with `upd_refused`=0.
- R8: An update to a locked page is refused: `upd_done`=1, `upd_refused`=1, and the record is left unchanged.
- R9: An accept request for an assigned page owned by `val_ctx` that has not yet been accepted succeeds with status 0 and marks the page accepted. The request is rejected with status 1 if the page is unassigned or owned by another context. It is rejected with status 2 if the page is already accepted. A rejected request leaves the record unchanged. `val_done` pulses one cycle after the request.
- R10: Permission bits for level L sit at `upd_perm[3L+2:3L]`: bit 0 read, bit 1 write, bit 2 execute. Access kind encoding is 0 read, 1 write, 2 execute, and 3 is treated as read. A missing right faults with code 5 (read), 6 (write) or 7 (execute).
- R11: Fault causes are reported by priority: unassigned (1), context (2), guest page (3), not accepted (4), permission (5 to 7).
- R12: When an update and an accept arrive in the same cycle, the accept is rejected with status 3. A check sees the table as it stood before any write made on the same edge as its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Host update request |
| upd_ppn | input | PN_W | Physical page number to update |
| upd_assign | input | 1 | 1 assigns the page, 0 releases it to the host |
| upd_lock | input | 1 | Lock the record against later updates |
| upd_ctx | input | CTX_W | Owning context |
| upd_gpa | input | GA_W | Guest-physical address the page must map to |
| upd_perm | input | 3*LEVELS | Per-level read/write/execute rights |
| upd_done | output | 1 | Update response strobe |
| upd_refused | output | 1 | Update refused because the page is locked |
| val_valid | input | 1 | Guest accept request |
| val_ppn | input | PN_W | Physical page number to accept |
| val_ctx | input | CTX_W | Requesting context |
| val_done | output | 1 | Accept response strobe |
| val_status | output | 2 | 0 ok, 1 not owner, 2 already accepted, 3 collided with update |
| chk_valid | input | 1 | Check request |
| chk_pa | input | PN_W+12 | System physical address of the access |
| chk_private | input | 1 | Access targets a private page |
| chk_gpa | input | GA_W | Guest-physical address of the access |
| chk_ctx | input | CTX_W | Context issuing the access |
| chk_lvl | input | clog2(LEVELS) | Privilege level, 0 most privileged |
| chk_kind | input | 2 | Access kind |
| res_valid | output | 1 | Check result strobe |
| res_fault | output | 1 | Access faults |
| res_code | output | 3 | Fault code, 0 on pass |

## Verification
The hardest case to reach is a collision on a single edge. Here an accept, an update and a check all touch one page together, and the check must return the state before the write while the accept reports the collision. The bench drives these collisions on purpose. It then runs a long random phase over a small set of pages and contexts, so that reassignments, locks, repeated accepts and back-to-back checks overlap on the same records. A cycle-level reference model judges every result.

// File: rtl/pgown_pkg.sv
package pgown_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int PERM_BITS  = 3;
  localparam int PB_R = 0;
  localparam int PB_W = 1;
  localparam int PB_X = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_UNOWNED = 3'd1,
    FLT_CTX     = 3'd2,
    FLT_GPA     = 3'd3,
    FLT_UNVAL   = 3'd4,
    FLT_NO_R    = 3'd5,
    FLT_NO_W    = 3'd6,
    FLT_NO_X    = 3'd7
  } flt_code_e;

  typedef enum logic [1:0] {
    VST_OK        = 2'd0,
    VST_NOT_OWNER = 2'd1,
    VST_ALREADY   = 2'd2,
    VST_BUSY      = 2'd3
  } val_status_e;
endpackage

// File: rtl/pgown_store.sv
module pgown_store #(
  parameter int IDX_W = 6,
  parameter int ENT_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [IDX_W-1:0] chk_addr,
  output logic [ENT_W-1:0] chk_data,
  input  logic [IDX_W-1:0] upd_addr,
  output logic [ENT_W-1:0] upd_data,
  input  logic [IDX_W-1:0] val_addr,
  output logic [ENT_W-1:0] val_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];

  // Check path reads synchronously; the read returns pre-write contents.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      chk_data <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      chk_data <= mem[chk_addr];
    end
  end

  // Admin paths need the current record in the request cycle.
  assign upd_data = mem[upd_addr];
  assign val_data = mem[val_addr];
endmodule

// File: rtl/pgown_admin.sv
module pgown_admin
  import pgown_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int CTX_W  = 8,
  parameter int GPN_W  = 20,
  parameter int PERM_W = 12,
  localparam int ENT_W = 3 + CTX_W + GPN_W + PERM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_ppn,
  input  logic              upd_assign,
  input  logic              upd_lock,
  input  logic [CTX_W-1:0]  upd_ctx,
  input  logic [GPN_W-1:0]  upd_gpn,
  input  logic [PERM_W-1:0] upd_perm,
  input  logic [ENT_W-1:0]  upd_cur,
  input  logic              val_valid,
  input  logic [IDX_W-1:0]  val_ppn,
  input  logic [CTX_W-1:0]  val_ctx,
  input  logic [ENT_W-1:0]  val_cur,
  output logic              we,
  output logic [IDX_W-1:0]  waddr,
  output logic [ENT_W-1:0]  wdata,
  output logic              upd_done,
  output logic              upd_refused,
  output logic              val_done,
  output logic [1:0]        val_status
);
  typedef struct packed {
    logic              assigned;
    logic              locked;
    logic              granted;
    logic [CTX_W-1:0]  ctx;
    logic [GPN_W-1:0]  gpn;
    logic [PERM_W-1:0] perm;
  } entry_t;

  entry_t ucur, vcur, fresh, accepted;
  logic   upd_ok, val_go;
  val_status_e vstat_n;

  assign ucur = upd_cur;
  assign vcur = val_cur;

  assign upd_ok = upd_valid && !ucur.locked;

  always_comb begin
    vstat_n = VST_OK;
    if (upd_valid)                                vstat_n = VST_BUSY;
    else if (!vcur.assigned || vcur.ctx != val_ctx) vstat_n = VST_NOT_OWNER;
    else if (vcur.granted)                        vstat_n = VST_ALREADY;
  end

  assign val_go = val_valid && (vstat_n == VST_OK);

  always_comb begin
    fresh          = '0;
    fresh.assigned = upd_assign;
    fresh.locked   = upd_lock;
    fresh.granted  = 1'b0;
    fresh.ctx      = upd_ctx;
    fresh.gpn      = upd_gpn;
    fresh.perm     = upd_perm;
    accepted         = vcur;
    accepted.granted = 1'b1;
  end

  assign we    = upd_ok || val_go;
  assign waddr = upd_ok ? upd_ppn : val_ppn;
  assign wdata = upd_ok ? fresh : accepted;

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_done    <= 1'b0;
      upd_refused <= 1'b0;
      val_done    <= 1'b0;
      val_status  <= 2'd0;
    end else begin
      upd_done    <= upd_valid;
      upd_refused <= upd_valid && ucur.locked;
      val_done    <= val_valid;
      val_status  <= val_valid ? vstat_n : VST_OK;
    end
  end
endmodule

// File: rtl/pgown_judge.sv
module pgown_judge
  import pgown_pkg::*;
#(
  parameter int CTX_W  = 8,
  parameter int GPN_W  = 20,
  parameter int LEVELS = 4,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int PERM_W = PERM_BITS * LEVELS,
  localparam int ENT_W  = 3 + CTX_W + GPN_W + PERM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_private,
  input  logic [GPN_W-1:0] req_gpn,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic [1:0]       req_kind,
  input  logic [ENT_W-1:0] entry,
  output logic             res_valid,
  output logic             res_fault,
  output logic [2:0]       res_code
);
  typedef struct packed {
    logic              assigned;
    logic              locked;
    logic              granted;
    logic [CTX_W-1:0]  ctx;
    logic [GPN_W-1:0]  gpn;
    logic [PERM_W-1:0] perm;
  } entry_t;

  entry_t ent;
  logic [PERM_BITS-1:0] lvl_perm [LEVELS];
  logic [PERM_BITS-1:0] sel;
  flt_code_e code_n;

  assign ent = entry;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign lvl_perm[g] = ent.perm[g*PERM_BITS +: PERM_BITS];
  end

  assign sel = lvl_perm[req_lvl];

  always_comb begin
    code_n = FLT_NONE;
    if (!req_private)             code_n = FLT_NONE;
    else if (!ent.assigned)       code_n = FLT_UNOWNED;
    else if (ent.ctx != req_ctx)  code_n = FLT_CTX;
    else if (ent.gpn != req_gpn)  code_n = FLT_GPA;
    else if (!ent.granted)        code_n = FLT_UNVAL;
    else begin
      case (acc_kind_e'(req_kind))
        ACC_WRITE: if (!sel[PB_W]) code_n = FLT_NO_W;
        ACC_EXEC:  if (!sel[PB_X]) code_n = FLT_NO_X;
        default:   if (!sel[PB_R]) code_n = FLT_NO_R;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_code  <= 3'd0;
    end else begin
      res_valid <= req_valid;
      res_fault <= req_valid && (code_n != FLT_NONE);
      res_code  <= req_valid ? code_n : FLT_NONE;
    end
  end
endmodule

// File: rtl/page_owner_check.sv
module page_owner_check
  import pgown_pkg::*;
#(
  parameter int PN_W   = 6,
  parameter int GA_W   = 32,
  parameter int CTX_W  = 8,
  parameter int LEVELS = 4,
  localparam int PA_W   = PN_W + PAGE_SHIFT,
  localparam int GPN_W  = GA_W - PAGE_SHIFT,
  localparam int PERM_W = PERM_BITS * LEVELS,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int ENT_W  = 3 + CTX_W + GPN_W + PERM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [PN_W-1:0]   upd_ppn,
  input  logic              upd_assign,
  input  logic              upd_lock,
  input  logic [CTX_W-1:0]  upd_ctx,
  input  logic [GA_W-1:0]   upd_gpa,
  input  logic [PERM_W-1:0] upd_perm,
  output logic              upd_done,
  output logic              upd_refused,
  input  logic              val_valid,
  input  logic [PN_W-1:0]   val_ppn,
  input  logic [CTX_W-1:0]  val_ctx,
  output logic              val_done,
  output logic [1:0]        val_status,
  input  logic              chk_valid,
  input  logic [PA_W-1:0]   chk_pa,
  input  logic              chk_private,
  input  logic [GA_W-1:0]   chk_gpa,
  input  logic [CTX_W-1:0]  chk_ctx,
  input  logic [LVL_W-1:0]  chk_lvl,
  input  logic [1:0]        chk_kind,
  output logic              res_valid,
  output logic              res_fault,
  output logic [2:0]        res_code
);
  logic              we;
  logic [PN_W-1:0]   waddr;
  logic [ENT_W-1:0]  wdata, chk_ent, upd_cur, val_cur;

  logic              s1_valid, s1_private;
  logic [GPN_W-1:0]  s1_gpn;
  logic [CTX_W-1:0]  s1_ctx;
  logic [LVL_W-1:0]  s1_lvl;
  logic [1:0]        s1_kind;

  logic unused_offsets;
  assign unused_offsets = ^{chk_pa[PAGE_SHIFT-1:0], chk_gpa[PAGE_SHIFT-1:0],
                            upd_gpa[PAGE_SHIFT-1:0]};

  pgown_store #(.IDX_W(PN_W), .ENT_W(ENT_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata),
    .chk_addr (chk_pa[PA_W-1:PAGE_SHIFT]),
    .chk_data (chk_ent),
    .upd_addr (upd_ppn),
    .upd_data (upd_cur),
    .val_addr (val_ppn),
    .val_data (val_cur)
  );

  pgown_admin #(.IDX_W(PN_W), .CTX_W(CTX_W), .GPN_W(GPN_W), .PERM_W(PERM_W)) u_admin (
    .clk         (clk),
    .rst         (rst),
    .upd_valid   (upd_valid),
    .upd_ppn     (upd_ppn),
    .upd_assign  (upd_assign),
    .upd_lock    (upd_lock),
    .upd_ctx     (upd_ctx),
    .upd_gpn     (upd_gpa[GA_W-1:PAGE_SHIFT]),
    .upd_perm    (upd_perm),
    .upd_cur     (upd_cur),
    .val_valid   (val_valid),
    .val_ppn     (val_ppn),
    .val_ctx     (val_ctx),
    .val_cur     (val_cur),
    .we          (we),
    .waddr       (waddr),
    .wdata       (wdata),
    .upd_done    (upd_done),
    .upd_refused (upd_refused),
    .val_done    (val_done),
    .val_status  (val_status)
  );

  // Stage 1: carry request fields alongside the table read.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_private <= 1'b0;
      s1_gpn     <= '0;
      s1_ctx     <= '0;
      s1_lvl     <= '0;
      s1_kind    <= 2'd0;
    end else begin
      s1_valid   <= chk_valid;
      s1_private <= chk_private;
      s1_gpn     <= chk_gpa[GA_W-1:PAGE_SHIFT];
      s1_ctx     <= chk_ctx;
      s1_lvl     <= chk_lvl;
      s1_kind    <= chk_kind;
    end
  end

  // Stage 2: compare and register the verdict.
  pgown_judge #(.CTX_W(CTX_W), .GPN_W(GPN_W), .LEVELS(LEVELS)) u_judge (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (s1_valid),
    .req_private (s1_private),
    .req_gpn     (s1_gpn),
    .req_ctx     (s1_ctx),
    .req_lvl     (s1_lvl),
    .req_kind    (s1_kind),
    .entry       (chk_ent),
    .res_valid   (res_valid),
    .res_fault   (res_fault),
    .res_code    (res_code)
  );
endmodule

// File: rtl/pgown_checker.sv
module pgown_checker (
  input logic       clk,
  input logic       rst,
  input logic       chk_valid,
  input logic       chk_private,
  input logic       upd_valid,
  input logic       val_valid,
  input logic       upd_done,
  input logic       upd_refused,
  input logic       val_done,
  input logic [1:0] val_status,
  input logic       res_valid,
  input logic       res_fault,
  input logic [2:0] res_code
);
  logic v1, v2, p1, p2, uv1, vv1, both1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; p1 <= 1'b0; p2 <= 1'b0;
      uv1 <= 1'b0; vv1 <= 1'b0; both1 <= 1'b0;
    end else begin
      v1 <= chk_valid;  v2 <= v1;
      p1 <= chk_private; p2 <= p1;
      uv1 <= upd_valid; vv1 <= val_valid;
      both1 <= upd_valid && val_valid;
    end
  end

  // R2
  res_latency_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid == v2);

  // R1
  res_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_fault && res_code == 3'd0));

  // R3
  shared_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !p2) |-> !res_fault);

  // R11
  fault_code_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_fault == (res_code != 3'd0)));

  // R7
  upd_resp_chk: assert property (@(posedge clk) disable iff (rst)
    upd_done == uv1);

  // R8
  refuse_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    upd_refused |-> upd_done);

  // R9
  val_resp_chk: assert property (@(posedge clk) disable iff (rst)
    val_done == vv1);

  // R12
  val_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (val_done && both1) |-> (val_status == 2'd3));
endmodule

bind page_owner_check pgown_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .chk_valid   (chk_valid),
  .chk_private (chk_private),
  .upd_valid   (upd_valid),
  .val_valid   (val_valid),
  .upd_done    (upd_done),
  .upd_refused (upd_refused),
  .val_done    (val_done),
  .val_status  (val_status),
  .res_valid   (res_valid),
  .res_fault   (res_fault),
  .res_code    (res_code)
);

// File: tb/page_owner_check_test.sv
`timescale 1ns/1ps
module page_owner_check_test;
  localparam int PN_W = 6, GA_W = 32, CTX_W = 8, LEVELS = 4;
  localparam int NPG = 1 << PN_W;
  localparam int PA_W = PN_W + 12;

  logic clk = 0, rst = 1;
  logic upd_valid = 0, upd_assign = 0, upd_lock = 0;
  logic [PN_W-1:0] upd_ppn = '0, val_ppn = '0;
  logic [CTX_W-1:0] upd_ctx = '0, val_ctx = '0, chk_ctx = '0;
  logic [GA_W-1:0] upd_gpa = '0, chk_gpa = '0;
  logic [11:0] upd_perm = '0;
  logic val_valid = 0, chk_valid = 0, chk_private = 0;
  logic [PA_W-1:0] chk_pa = '0;
  logic [1:0] chk_lvl = '0, chk_kind = '0;
  logic upd_done, upd_refused, val_done, res_valid, res_fault;
  logic [1:0] val_status;
  logic [2:0] res_code;

  always #5 clk = ~clk;

  page_owner_check uut (.*);

  int checks = 0, fails = 0;
  string tag = "R1";

  // reference model state
  bit m_asg[NPG], m_lock[NPG], m_ok[NPG];
  int m_ctx[NPG], m_gpn[NPG], m_perm[NPG];
  int q_code[$]; bit q_v[$]; string q_tag[$];
  bit e_rv; int e_code; string e_rtag = "R1";
  bit e_ud, e_ur, e_vd; int e_vs; string e_utag = "R1", e_vtag = "R1";

  function automatic int ref_code(int p, bit priv, int ctx, int gpn, int lvl, int kind);
    int bits;
    if (!priv) return 0;
    if (!m_asg[p]) return 1;
    if (m_ctx[p] != ctx) return 2;
    if (m_gpn[p] != gpn) return 3;
    if (!m_ok[p]) return 4;
    bits = (m_perm[p] >> (lvl * 3)) & 7;
    if (kind == 1) return ((bits & 2) != 0) ? 0 : 6;
    if (kind == 2) return ((bits & 4) != 0) ? 0 : 7;
    return ((bits & 1) != 0) ? 0 : 5;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPG; i++) begin
        m_asg[i] = 0; m_lock[i] = 0; m_ok[i] = 0; m_ctx[i] = 0; m_gpn[i] = 0; m_perm[i] = 0;
      end
      q_code.delete(); q_v.delete(); q_tag.delete();
      e_rv = 0; e_code = 0; e_ud = 0; e_ur = 0; e_vd = 0; e_vs = 0;
    end else begin
      int vs, up, vp;
      if (q_v.size() > 0) begin
        e_rv = q_v.pop_front(); e_code = q_code.pop_front(); e_rtag = q_tag.pop_front();
      end else begin
        e_rv = 0; e_code = 0;
      end
      q_v.push_back(chk_valid);
      q_code.push_back(chk_valid ? ref_code(int'(chk_pa >> 12), chk_private, int'(chk_ctx),
                         int'(chk_gpa >> 12), int'(chk_lvl), int'(chk_kind)) : 0);
      q_tag.push_back(tag);
      up = int'(upd_ppn); vp = int'(val_ppn);
      e_ud = upd_valid; e_ur = upd_valid && m_lock[up]; e_utag = tag;
      e_vd = val_valid; e_vtag = tag; vs = 0;
      if (val_valid) begin
        if (upd_valid) vs = 3;
        else if (!m_asg[vp] || m_ctx[vp] != int'(val_ctx)) vs = 1;
        else if (m_ok[vp]) vs = 2;
        else m_ok[vp] = 1;
      end
      e_vs = vs;
      if (upd_valid && !m_lock[up]) begin
        m_asg[up] = upd_assign; m_lock[up] = upd_lock; m_ok[up] = 0;
        m_ctx[up] = int'(upd_ctx); m_gpn[up] = int'(upd_gpa >> 12); m_perm[up] = int'(upd_perm);
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (res_valid !== e_rv || res_fault !== (e_code != 0) || int'(res_code) !== e_code) begin
      fails++;
      $display("FAIL %s check result: got v=%0b f=%0b c=%0d exp v=%0b f=%0b c=%0d",
               e_rtag, res_valid, res_fault, res_code, e_rv, e_code != 0, e_code);
    end
    checks++;
    if (upd_done !== e_ud || (e_ud && upd_refused !== e_ur)) begin
      fails++;
      $display("FAIL %s update resp: got d=%0b r=%0b exp d=%0b r=%0b",
               e_utag, upd_done, upd_refused, e_ud, e_ur);
    end
    checks++;
    if (val_done !== e_vd || (e_vd && int'(val_status) !== e_vs)) begin
      fails++;
      $display("FAIL %s accept resp: got d=%0b s=%0d exp d=%0b s=%0d",
               e_vtag, val_done, val_status, e_vd, e_vs);
    end
  end

  task automatic step();
    @(negedge clk);
    chk_valid = 0; upd_valid = 0; val_valid = 0;
  endtask

  task automatic set_upd(int p, bit asg, bit lk, int ctx, int gpn, int perm);
    upd_valid = 1; upd_ppn = p[PN_W-1:0]; upd_assign = asg; upd_lock = lk;
    upd_ctx = ctx[CTX_W-1:0]; upd_gpa = {gpn[19:0], 12'h0}; upd_perm = perm[11:0];
  endtask

  task automatic set_val(int p, int ctx);
    val_valid = 1; val_ppn = p[PN_W-1:0]; val_ctx = ctx[CTX_W-1:0];
  endtask

  task automatic set_chk(int p, bit priv, int ctx, int gpn, int lvl, int kind);
    chk_valid = 1; chk_pa = {p[PN_W-1:0], 12'h abc}; chk_private = priv;
    chk_ctx = ctx[CTX_W-1:0]; chk_gpa = {gpn[19:0], 12'h123};
    chk_lvl = lvl[1:0]; chk_kind = kind[1:0];
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    step();
    tag = "R4"; set_chk(5, 1, 3, 'h45, 0, 0); step();
    tag = "R3"; set_chk(5, 0, 3, 'h45, 0, 1); step();
    tag = "R7"; set_upd(5, 1, 0, 3, 'h45, 'hFFF); step();
    tag = "R6"; set_chk(5, 1, 3, 'h45, 0, 0); step();
    tag = "R9"; set_val(5, 3); step();
    set_val(5, 3); step();
    set_val(6, 3); step();
    set_val(5, 4); step();
    tag = "R5"; set_chk(5, 1, 3, 'h45, 2, 1); step();
    set_chk(5, 1, 4, 'h45, 0, 0); step();
    set_chk(5, 1, 3, 'h46, 0, 0); step();
    tag = "R10"; set_upd(7, 1, 0, 2, 'h90, 'h88F); step();
    set_val(7, 2); step();
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < 4; k++) begin
        set_chk(7, 1, 2, 'h90, l, k); step();
      end
    tag = "R7"; set_upd(5, 1, 0, 3, 'h45, 'hFFF); step();
    set_chk(5, 1, 3, 'h45, 0, 0); step();
    tag = "R8"; set_upd(9, 1, 1, 1, 'h20, 'h007); step();
    set_upd(9, 1, 0, 6, 'h21, 'hFFF); step();
    set_chk(9, 1, 1, 'h20, 0, 0); step();
    set_val(9, 1); step();
    set_chk(9, 1, 1, 'h20, 0, 0); step();
    set_chk(9, 1, 1, 'h20, 1, 0); step();
    tag = "R11"; set_chk(12, 1, 9, 'h77, 3, 2); step();
    set_chk(5, 1, 9, 'h77, 0, 0); step();
    set_chk(5, 1, 3, 'h77, 0, 0); step();
    set_chk(7, 1, 2, 'h90, 1, 2); step();
    tag = "R12"; set_upd(11, 1, 0, 5, 'h30, 'hFFF); set_val(5, 3); step();
    set_chk(5, 1, 3, 'h45, 0, 0); step();
    set_val(5, 3); set_chk(5, 1, 3, 'h45, 0, 0); step();
    set_chk(5, 1, 3, 'h45, 0, 0); step();
    set_upd(11, 1, 0, 5, 'h31, 'hFFF); set_chk(11, 1, 5, 'h30, 0, 0); step();
    set_chk(11, 1, 5, 'h31, 0, 0); step();
    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(3, 0) == 0)
        set_upd($urandom_range(3, 0), $urandom_range(7, 0) != 0, $urandom_range(40, 0) == 0,
                $urandom_range(2, 0), $urandom_range(1, 0), $urandom_range(4095, 0));
      if ($urandom_range(2, 0) == 0)
        set_val($urandom_range(3, 0), $urandom_range(2, 0));
      if ($urandom_range(4, 0) != 0)
        set_chk($urandom_range(3, 0), $urandom_range(5, 0) != 0, $urandom_range(2, 0),
                $urandom_range(1, 0), $urandom_range(3, 0), $urandom_range(3, 0));
      step();
    end
    repeat (4) step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got running exp finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule